// File: doc/BRIEF.md
# Dual-Slope PWM Timer with Programmable Ceiling

This block is an 8-bit up/down timer that produces center-aligned pulse-width modulation. Once started, the count climbs by one per tick to a ceiling, then falls back by one per tick to zero, and repeats. The ceiling is either fixed at 255 or taken from compare register A. The second choice lets software change the period while the timer runs. Compare register B sets the duty of output B. In the fixed-ceiling setting, compare register A also drives output A.

A tick comes from a free-running divider that the clock-select field taps. Code 0 halts the count. A sticky bottom flag is raised each time the count falls to zero. Software polls the flag and writes a 1 to clear it. Software typically waits for the flag once per period and then writes new compare values. The compare registers are double-buffered, so a new value never cuts into a period that is under way.

Top module: `dslope_pwm_timer`

## Requirements
- R1: While rst_n is low and right after it, every register (control, compare A, compare B, flag and count) reads 0 and both outputs are low.
- R2: While running, each tick moves the count by exactly one. It counts up until it equals the ceiling, turns and counts down to 0, then turns and counts up again. With ceiling T the period is 2T ticks.
- R3: Control bit 3 picks the ceiling: 0 gives a fixed 255, 1 gives the active value of compare A.
- R4: Output B is enabled by control bit 5 and is low when disabled. With compare B = C where 0 < C < ceiling, it goes low when the count reaches C on the way up and high when it reaches C on the way down. So it is high while counting up with count < C, and high while counting down with count <= C.
- R5: With output B enabled, compare B = 0 holds it high for the whole period, and compare B at or above the ceiling holds it low.
- R6: Output A is enabled by control bit 4. It obeys the rules of R4 and R5 with compare A when the ceiling is fixed (bit 3 = 0). It is held low whenever compare A is the ceiling.
- R7: Control bits [2:0] select the tick: 1 gives every clock, 2 gives one in 8, 3 one in 64, 4 one in 256, 5 one in 1024. Codes 0, 6 and 7 stop the count, which then holds its value.
- R8: The flag (address 3, bit 0) is set on the tick where the count steps from 1 to 0 while counting down. It stays set until cleared.
- R9: Writing address 3 with bit 0 = 1 clears the flag. Writing it with bit 0 = 0 leaves the flag unchanged.
- R10: While the timer runs, values written to compare A (address 1) and compare B (address 2) take effect only on the tick that turns the count around at the ceiling. While it is stopped they take effect at once. The count reads at address 4 and control at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Register write strobe, sampled on the rising edge |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 8 | Combinational read data |
| pwm_a | output | 1 | Waveform from compare A |
| pwm_b | output | 1 | Waveform from compare B |

## Verification
Some properties are checked on every cycle: the count moving up by one below the ceiling, the count freezing when no tick arrives, the flag staying set without a clearing write, the compare buffers holding still between turnarounds, and output A staying low when compare A is the ceiling. Other behaviour only the bench scenarios can show. These are the full triangle shape and output waveform for several ceilings and duties, and a ceiling raised in mid-period taking hold only after the next peak. They also cover the exact spacing of ticks at each divide ratio and the write-1-clear rule for the flag.

// File: rtl/dspwm_pkg.sv
package dspwm_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [2:0] {
    CS_STOP    = 3'd0,
    CS_DIV1    = 3'd1,
    CS_DIV8    = 3'd2,
    CS_DIV64   = 3'd3,
    CS_DIV256  = 3'd4,
    CS_DIV1024 = 3'd5
  } clk_sel_e;

  localparam logic [ADDR_W-1:0] RA_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] RA_CMPA  = 3'd1;
  localparam logic [ADDR_W-1:0] RA_CMPB  = 3'd2;
  localparam logic [ADDR_W-1:0] RA_FLAG  = 3'd3;
  localparam logic [ADDR_W-1:0] RA_COUNT = 3'd4;

  localparam int CTRL_TOPA_BIT = 3;
  localparam int CTRL_ENA_BIT  = 4;
  localparam int CTRL_ENB_BIT  = 5;

  function automatic logic sel_running(logic [2:0] s);
    return (s != 3'd0) && (s <= 3'd5);
  endfunction
endpackage

// File: rtl/dspwm_prescaler.sv
module dspwm_prescaler
  import dspwm_pkg::*;
#(
  parameter int DIV_W = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel,
  output logic       tick
);
  localparam int TAP8    = 3;
  localparam int TAP64   = 6;
  localparam int TAP256  = 8;
  localparam int TAP1024 = 10;
  localparam logic [DIV_W-1:0] ONE = {{(DIV_W-1){1'b0}}, 1'b1};

  logic [DIV_W-1:0] div_q, div_d;

  assign div_d = div_q + ONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  always_comb begin
    case (sel)
      CS_DIV1:    tick = 1'b1;
      CS_DIV8:    tick = &div_q[TAP8-1:0];
      CS_DIV64:   tick = &div_q[TAP64-1:0];
      CS_DIV256:  tick = &div_q[TAP256-1:0];
      CS_DIV1024: tick = &div_q[TAP1024-1:0];
      default:    tick = 1'b0;
    endcase
  end
endmodule

// File: rtl/dspwm_updown.sv
module dspwm_updown #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         running,
  input  logic         top_from_a,
  input  logic [W-1:0] cmpa_reg,
  input  logic [W-1:0] cmpb_reg,
  output logic [W-1:0] cnt,
  output logic         up,
  output logic [W-1:0] top_val,
  output logic [W-1:0] cmpa_act,
  output logic [W-1:0] cmpb_act,
  output logic         bottom_hit
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q, cnt_d, cmpa_q, cmpa_d, cmpb_q, cmpb_d;
  logic         up_q, up_d, at_top, load;

  assign top_val    = top_from_a ? cmpa_q : '1;
  assign at_top     = up_q && (cnt_q >= top_val);
  assign load       = !running || (tick && at_top);
  assign bottom_hit = tick && !up_q && (cnt_q == ONE);

  always_comb begin
    cnt_d  = cnt_q;
    up_d   = up_q;
    cmpa_d = load ? cmpa_reg : cmpa_q;
    cmpb_d = load ? cmpb_reg : cmpb_q;
    if (tick) begin
      if (up_q) begin
        if (at_top) begin
          up_d  = 1'b0;
          cnt_d = (cnt_q == '0) ? '0 : cnt_q - ONE;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end else if (cnt_q == '0) begin
        up_d  = 1'b1;
        cnt_d = (top_val == '0) ? '0 : ONE;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      up_q   <= 1'b1;
      cmpa_q <= '0;
      cmpb_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      up_q   <= up_d;
      cmpa_q <= cmpa_d;
      cmpb_q <= cmpb_d;
    end
  end

  assign cnt      = cnt_q;
  assign up       = up_q;
  assign cmpa_act = cmpa_q;
  assign cmpb_act = cmpb_q;

  // R2
  cnt_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && up_q && (cnt_q < top_val)) |=> (cnt_q == W'($past(cnt_q) + ONE)));

  // R7
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));

  // R10
  cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !(tick && at_top)) |=> ($stable(cmpa_q) && $stable(cmpb_q)));
endmodule

// File: rtl/dspwm_wave.sv
module dspwm_wave #(
  parameter int W = 8
) (
  input  logic         en,
  input  logic [W-1:0] cmp,
  input  logic [W-1:0] top,
  input  logic [W-1:0] cnt,
  input  logic         up,
  output logic         wave
);
  always_comb begin
    if (!en)              wave = 1'b0;
    else if (cmp == '0)   wave = 1'b1;
    else if (cmp >= top)  wave = 1'b0;
    else if (up)          wave = (cnt < cmp);
    else                  wave = (cnt <= cmp);
  end
endmodule

// File: rtl/dslope_pwm_timer.sv
module dslope_pwm_timer
  import dspwm_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DIV_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  output logic              pwm_a,
  output logic              pwm_b
);
  localparam int NCH = 2;

  logic [CNT_W-1:0] ctrl_q, ctrl_d, cmpa_q, cmpa_d, cmpb_q, cmpb_d;
  logic             ovf_q, ovf_d, flag_clr;
  logic             tick, running, up, bottom_hit;
  logic [CNT_W-1:0] cnt, top_val, cmpa_act, cmpb_act;
  logic [NCH-1:0]   ch_en, ch_out;
  logic [CNT_W-1:0] ch_cmp [NCH];

  assign running  = sel_running(ctrl_q[2:0]);
  assign flag_clr = wr_en && (wr_addr == RA_FLAG) && wr_data[0];

  always_comb begin
    ctrl_d = ctrl_q;
    cmpa_d = cmpa_q;
    cmpb_d = cmpb_q;
    if (wr_en) begin
      case (wr_addr)
        RA_CTRL: ctrl_d = wr_data;
        RA_CMPA: cmpa_d = wr_data;
        RA_CMPB: cmpb_d = wr_data;
        default: ;
      endcase
    end
    ovf_d = bottom_hit || (ovf_q && !flag_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cmpa_q <= '0;
      cmpb_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      cmpa_q <= cmpa_d;
      cmpb_q <= cmpb_d;
      ovf_q  <= ovf_d;
    end
  end

  dspwm_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .sel(ctrl_q[2:0]), .tick(tick)
  );

  dspwm_updown #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .running(running),
    .top_from_a(ctrl_q[CTRL_TOPA_BIT]), .cmpa_reg(cmpa_q), .cmpb_reg(cmpb_q),
    .cnt(cnt), .up(up), .top_val(top_val), .cmpa_act(cmpa_act),
    .cmpb_act(cmpb_act), .bottom_hit(bottom_hit)
  );

  assign ch_en[0]  = ctrl_q[CTRL_ENA_BIT] && !ctrl_q[CTRL_TOPA_BIT];
  assign ch_en[1]  = ctrl_q[CTRL_ENB_BIT];
  assign ch_cmp[0] = cmpa_act;
  assign ch_cmp[1] = cmpb_act;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    dspwm_wave #(.W(CNT_W)) u_wave (
      .en(ch_en[ch]), .cmp(ch_cmp[ch]), .top(top_val),
      .cnt(cnt), .up(up), .wave(ch_out[ch])
    );
  end

  assign pwm_a = ch_out[0];
  assign pwm_b = ch_out[1];

  always_comb begin
    case (rd_addr)
      RA_CTRL:  rd_data = ctrl_q;
      RA_CMPA:  rd_data = cmpa_q;
      RA_CMPB:  rd_data = cmpb_q;
      RA_FLAG:  rd_data = {{(CNT_W-1){1'b0}}, ovf_q};
      RA_COUNT: rd_data = cnt;
      default:  rd_data = '0;
    endcase
  end

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !flag_clr) |=> ovf_q);

  // R6
  pwm_a_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[CTRL_TOPA_BIT] |-> !pwm_a);

  // R7
  stop_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> $stable(cnt));
endmodule

// File: tb/dslope_pwm_timer_tb.sv
module dslope_pwm_timer_tb;
  localparam time TCLK = 5ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       pwm_a, pwm_b;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(TCLK/2) clk = ~clk;

  dslope_pwm_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .pwm_a(pwm_a), .pwm_b(pwm_b)
  );

  typedef struct {
    int         req_c, req_a, req_b;
    logic [7:0] cnt;
    logic       chk_a, pa, chk_b, pb;
  } exp_t;
  exp_t sb_q[$];

  task automatic chk(int req, string what, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: pops one expected item per cycle, compares at the falling edge
  always @(negedge clk) begin
    exp_t e;
    if (sb_q.size() > 0) begin
      e = sb_q.pop_front();
      #1;
      chk(e.req_c, "count", int'(rd_data), int'(e.cnt));
      if (e.chk_a) chk(e.req_a, "pwm_a", int'(pwm_a), int'(e.pa));
      if (e.chk_b) chk(e.req_b, "pwm_b", int'(pwm_b), int'(e.pb));
    end
  end

  function automatic logic [7:0] tri_cnt(int k, int t);
    int p = k % (2*t);
    return (p <= t) ? 8'(p) : 8'(2*t - p);
  endfunction

  function automatic logic tri_up(int k, int t);
    int p = k % (2*t);
    return (p < t) && !(p == 0 && k > 0);
  endfunction

  function automatic logic rule(int c, int t, logic [7:0] cnt, logic upd);
    if (c == 0) return 1'b1;
    if (c >= t) return 1'b0;
    return upd ? (int'(cnt) < c) : (int'(cnt) <= c);
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    rd_addr = a;
    #1 v = rd_data;
  endtask

  // driver: pushes the expected triangle state for each cycle after a start
  task automatic run_tri(int req_c, int n, int t, int ca, logic ena, int req_a,
                         int cb, logic enb, int req_b);
    exp_t e;
    rd_addr = 3'd4;
    for (int k = 0; k < n; k++) begin
      e.req_c = req_c; e.req_a = req_a; e.req_b = req_b;
      e.cnt   = tri_cnt(k, t);
      e.chk_a = 1'b1; e.chk_b = 1'b1;
      e.pa = ena && rule(ca, t, e.cnt, tri_up(k, t));
      e.pb = enb && rule(cb, t, e.cnt, tri_up(k, t));
      sb_q.push_back(e);
      @(posedge clk);
      #1;
    end
    wait (sb_q.size() == 0);
  endtask

  task automatic measure(int exp_gap);
    logic [7:0] v0, v1;
    int gap, guard;
    rd(3'd4, v0);
    guard = 0;
    do begin rd(3'd4, v1); guard++; end while (v1 == v0 && guard < 3000);
    v0 = v1; gap = 0;
    do begin rd(3'd4, v1); gap++; end while (v1 == v0 && gap < 3000);
    // R7 tick spacing
    chk(7, "tick spacing", gap, exp_gap);
  endtask

  initial begin
    #(TCLK * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, v2;
    exp_t e;
    static int s3_seq[22] = '{0,1,2,3,4,3,2,1,0,1,2,3,4,5,6,5,4,3,2,1,0,1};

    // R1 reset state
    do_reset();
    rd(3'd4, v); chk(1, "count after reset", int'(v), 0);
    rd(3'd3, v); chk(1, "flag after reset", int'(v), 0);
    rd(3'd0, v); chk(1, "ctrl after reset", int'(v), 0);
    rd(3'd1, v); chk(1, "cmpa after reset", int'(v), 0);
    chk(1, "pwm_a after reset", int'(pwm_a), 0);
    chk(1, "pwm_b after reset", int'(pwm_b), 0);

    // R2 R3 R4 R6: ceiling from compare A = 4, duty 2, A forced low
    wr(3'd1, 8'd4); wr(3'd2, 8'd2);
    wr(3'd0, 8'h39);
    run_tri(2, 20, 4, 2, 1'b0, 6, 2, 1'b1, 4);
    wr(3'd0, 8'h38);
    // R8 flag set at bottom
    rd(3'd3, v); chk(8, "flag after bottom", int'(v), 1);
    // R7 count holds while stopped
    rd(3'd4, v); repeat (6) @(posedge clk);
    rd(3'd4, v2); chk(7, "count held while stopped", int'(v2), int'(v));
    // R9 write 0 keeps, write 1 clears
    wr(3'd3, 8'hFE); rd(3'd3, v); chk(9, "flag after write 0", int'(v), 1);
    wr(3'd3, 8'h01); rd(3'd3, v); chk(9, "flag after write 1", int'(v), 0);

    // R10 ceiling raised mid-period takes hold after the next peak; R4 disabled B low
    do_reset();
    wr(3'd1, 8'd4); wr(3'd2, 8'd2);
    wr(3'd0, 8'h09);
    rd_addr = 3'd4;
    for (int k = 0; k < 22; k++) begin
      e.req_c = 10; e.req_a = 6; e.req_b = 4;
      e.cnt = 8'(s3_seq[k]);
      e.chk_a = 1'b1; e.pa = 1'b0;
      e.chk_b = 1'b1; e.pb = 1'b0;
      sb_q.push_back(e);
      if (k == 2) begin wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'd6; end
      @(posedge clk);
      #1 wr_en = 1'b0;
    end
    wait (sb_q.size() == 0);
    rd(3'd3, v); chk(8, "flag after two bottoms", int'(v), 1);

    // R5 extremes of compare B
    do_reset();
    wr(3'd1, 8'd4); wr(3'd2, 8'd0); wr(3'd0, 8'h29);
    run_tri(2, 12, 4, 0, 1'b0, 6, 0, 1'b1, 5);
    do_reset();
    wr(3'd1, 8'd4); wr(3'd2, 8'd4); wr(3'd0, 8'h29);
    run_tri(2, 12, 4, 0, 1'b0, 6, 4, 1'b1, 5);
    do_reset();
    wr(3'd1, 8'd4); wr(3'd2, 8'd9); wr(3'd0, 8'h29);
    run_tri(2, 12, 4, 0, 1'b0, 6, 9, 1'b1, 5);

    // R3 fixed ceiling 255, R6 output A from compare A, R4 output B
    do_reset();
    wr(3'd1, 8'd100); wr(3'd2, 8'd30); wr(3'd0, 8'h31);
    run_tri(3, 521, 255, 100, 1'b1, 6, 30, 1'b1, 4);

    // R7 divide ratios and unused codes
    do_reset();
    wr(3'd1, 8'd200);
    wr(3'd0, 8'h0A); measure(8);
    wr(3'd0, 8'h0B); measure(64);
    wr(3'd0, 8'h0C); measure(256);
    wr(3'd0, 8'h0D); measure(1024);
    wr(3'd0, 8'h0E);
    rd(3'd4, v); repeat (40) @(posedge clk);
    rd(3'd4, v2); chk(7, "code 6 holds count", int'(v2), int'(v));

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule